// File: doc/BRIEF.md
# Half-Duplex Three-Wire SPI Master

This block drives a serial link that has one bidirectional data line, a serial clock and an active-low chip select. A transaction begins with a start pulse that carries two bit counts. The master first shifts out the command and payload bits, which it takes as 32-bit words from a ready/valid transmit port. It then releases the data line and runs a fixed turnaround of clock steps. After that it shifts in the response bits and hands them over as 32-bit words on a ready/valid receive port. The last word of every response is the device's status word.

The serial clock is built from internal steps, one step every `STEP_DIV` core clocks. Each bit takes a low step followed by a high step. The master drives write data while the clock is low, so the device samples it on the rising edge. In the read phase the master samples the line at the step where it pulls the clock low. Once the read phase is over, the clock stays low and the data line stays released. When the device pulls the line high at a step, the master sets a sticky interrupt flag, which the host clears.

Software sets `wr_bits` to N*32-1 for a write of N words, or to 31 for a single command. It sets `rd_bits` to M*32+31, where M is the number of data words to read, and the status word is the extra 32 bits.

Top module: `tw_spi_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `sdio_oe` is 1 with `sdio_o` at 0, and `busy` and `irq` are 0.
- R2: The write phase puts exactly `wr_bits`+1 bits on `sdio_o` while `sdio_oe` is 1. The bits are taken from consecutive transmit words, bit 31 of each word first. Each bit is set up while `spi_sclk` is low and is valid at the rising edge that follows.
- R3: After the last write bit, `sdio_oe` falls while `spi_sclk` is low. The clock then gives exactly two rising edges (high, low, high) before the first read sample is taken.
- R4: The read phase samples `sdio_i` exactly `rd_bits`+1 times. Each sample is taken at the step where the clock is driven low. The first bit sampled lands in bit 31, and every 32 samples make one word on `rx_data`. The final word delivered is the trailing status word.
- R5: Every high phase of `spi_sclk` lasts exactly `STEP_DIV` core clocks. No low phase is shorter than that.
- R6: `busy` is the inverse of `spi_cs_n`. Both are set from the accepted start until the final received word has been accepted. A `start` that arrives while `busy` is 1 has no effect on the transaction in progress.
- R7: If the next write bit is due and no transmit word is held, the clock stays low and no further bits are sent until a word is accepted.
- R8: While `rx_valid` is 1 and `rx_ready` is 0, `rx_data` holds steady. No further bit is sampled, and the clock stays low until the word is accepted.
- R9: After the read phase, a step at which `sdio_i` is 1 sets `irq`. `irq` stays at 1 until `irq_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction when idle |
| wr_bits | input | CNT_W | Write bit count minus one |
| rd_bits | input | CNT_W | Read bit count minus one |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes received word |
| irq | output | 1 | Sticky event flag |
| irq_clr | input | 1 | Clear event flag |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input value |

## Verification
The hardest situations to reach from the ports are stalls that land in the middle of a phase. One is a transmit word that arrives only after the previous word's last bit has been clocked out. The other is a received word left pending while more read bits are still owed. The bench reaches both with directed runs. In one, it holds the second transmit word back for a long gap. In the other, it keeps `rx_ready` low until the first word is full, then checks that the edge count, the clock level and the held word do not move. A device model counts the rising edges after release to place its response bits. This means any error in the turnaround length shows up as misaligned received words. Random transactions then mix word counts, transmit gaps and receive back-pressure.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;

    localparam int WORD_W = 32;
    localparam int WCNT_W = $clog2(WORD_W + 1);

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WR_LO,
        PH_WR_HI,
        PH_REL,
        PH_TA_HI0,
        PH_TA_LO,
        PH_TA_HI1,
        PH_RD_LO,
        PH_RD_HI,
        PH_FIN,
        PH_DRAIN
    } phase_e;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic dout;
        logic oe;
    } pins_t;

    localparam pins_t PINS_RESET = '{sclk: 1'b0, cs_n: 1'b1, dout: 1'b0, oe: 1'b1};

    function automatic phase_e ta_next(input phase_e p);
        case (p)
            PH_REL:    return PH_TA_HI0;
            PH_TA_HI0: return PH_TA_LO;
            PH_TA_LO:  return PH_TA_HI1;
            default:   return PH_RD_LO;
        endcase
    endfunction

    function automatic logic ta_sclk(input phase_e p);
        return (p == PH_TA_HI0) || (p == PH_TA_LO);
    endfunction

endpackage

// File: rtl/tw_spi_step_gen.sv
module tw_spi_step_gen #(
    parameter int STEP_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (STEP_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(STEP_DIV);
            localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || cnt_q == LAST) cnt_q <= '0;
                else                      cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tw_spi_tx_shift.sv
module tw_spi_tx_shift
    import tw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              want,
    input  logic              shift,
    input  logic              flush,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              have_bit,
    output logic              bit_out
);
    logic [WORD_W-1:0] sr_q;
    logic [WCNT_W-1:0] left_q;

    assign tx_ready = want && (left_q == '0);
    assign have_bit = (left_q != '0);
    assign bit_out  = sr_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (flush) begin
            left_q <= '0;
        end else if (shift) begin
            sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end else if (tx_valid && tx_ready) begin
            sr_q   <= tx_data;
            left_q <= WCNT_W'(WORD_W);
        end
    end
endmodule

// File: rtl/tw_spi_rx_shift.sv
module tw_spi_rx_shift
    import tw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] word_q;
    logic [BC_W-1:0]   cnt_q;
    logic              full_q;

    assign rx_data  = word_q;
    assign rx_valid = full_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            if (rst) begin
                sr_q   <= '0;
                word_q <= '0;
            end
        end else begin
            if (full_q && rx_ready) full_q <= 1'b0;
            if (sample) begin
                sr_q <= {sr_q[WORD_W-2:0], din};
                if (cnt_q == LAST_BIT) begin
                    word_q <= {sr_q[WORD_W-2:0], din};
                    full_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tw_spi_master.sv
module tw_spi_master
    import tw_spi_pkg::*;
#(
    parameter int STEP_DIV = 2,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] wr_bits,
    input  logic [CNT_W-1:0] rd_bits,
    output logic             busy,
    input  logic [31:0]      tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [31:0]      rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             irq,
    input  logic             irq_clr,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             sdio_o,
    output logic             sdio_oe,
    input  logic             sdio_i
);
    phase_e           ph_q;
    pins_t            pin_q;
    logic [CNT_W-1:0] wcnt_q, rcnt_q;
    logic             evt_arm_q, irq_q;
    logic             tick;
    logic             tx_have, tx_bit, tx_shift, tx_flush;
    logic             rx_sample, rx_full, start_ok;

    tw_spi_step_gen #(.STEP_DIV(STEP_DIV)) u_step (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    assign start_ok = start && (ph_q == PH_IDLE);
    assign tx_shift = tick && (ph_q == PH_WR_HI);
    assign tx_flush = tx_shift && (wcnt_q == '0);
    assign rx_sample = tick && (ph_q == PH_RD_LO) && !rx_full;

    tw_spi_tx_shift u_tx (
        .clk     (clk),
        .rst     (rst),
        .want    (ph_q == PH_WR_LO),
        .shift   (tx_shift),
        .flush   (tx_flush || start_ok),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .have_bit(tx_have),
        .bit_out (tx_bit)
    );

    tw_spi_rx_shift u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .sample  (rx_sample),
        .din     (sdio_i),
        .rx_ready(rx_ready),
        .rx_data (rx_data),
        .rx_valid(rx_full)
    );

    assign rx_valid = rx_full;
    assign busy     = (ph_q != PH_IDLE);
    assign irq      = irq_q;
    assign spi_sclk = pin_q.sclk;
    assign spi_cs_n = pin_q.cs_n;
    assign sdio_o   = pin_q.dout;
    assign sdio_oe  = pin_q.oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            pin_q     <= PINS_RESET;
            wcnt_q    <= '0;
            rcnt_q    <= '0;
            evt_arm_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (irq_clr) irq_q <= 1'b0;
            if (tick && evt_arm_q && sdio_i) begin
                irq_q     <= 1'b1;
                evt_arm_q <= 1'b0;
            end
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        pin_q     <= '{sclk: 1'b0, cs_n: 1'b0, dout: 1'b0, oe: 1'b1};
                        wcnt_q    <= wr_bits;
                        rcnt_q    <= rd_bits;
                        evt_arm_q <= 1'b0;
                        ph_q      <= PH_WR_LO;
                    end
                end
                PH_WR_LO: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b0;
                        if (tx_have) begin
                            pin_q.dout <= tx_bit;
                            ph_q       <= PH_WR_HI;
                        end
                    end
                end
                PH_WR_HI: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b1;
                        if (wcnt_q == '0) begin
                            ph_q <= PH_REL;
                        end else begin
                            wcnt_q <= wcnt_q - 1'b1;
                            ph_q   <= PH_WR_LO;
                        end
                    end
                end
                PH_REL: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b0;
                        pin_q.oe   <= 1'b0;
                        ph_q       <= ta_next(ph_q);
                    end
                end
                PH_TA_HI0, PH_TA_LO, PH_TA_HI1: begin
                    if (tick) begin
                        pin_q.sclk <= ~ta_sclk(ph_q) | (ph_q == PH_TA_HI0);
                        ph_q       <= ta_next(ph_q);
                    end
                end
                PH_RD_LO: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b0;
                        if (!rx_full) ph_q <= PH_RD_HI;
                    end
                end
                PH_RD_HI: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b1;
                        if (rcnt_q == '0) begin
                            ph_q <= PH_FIN;
                        end else begin
                            rcnt_q <= rcnt_q - 1'b1;
                            ph_q   <= PH_RD_LO;
                        end
                    end
                end
                PH_FIN: begin
                    if (tick) begin
                        pin_q.sclk <= 1'b0;
                        evt_arm_q  <= 1'b1;
                        ph_q       <= PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    if (!rx_full) begin
                        pin_q.cs_n <= 1'b1;
                        ph_q       <= PH_IDLE;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tw_spi_master_chk.sv
module tw_spi_master_chk #(
    parameter int STEP_DIV = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [31:0] rx_data,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        irq,
    input logic        irq_clr,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        sdio_oe
);
    localparam int HW = $clog2(STEP_DIV + 2) + 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)           hi_cnt <= '0;
        else if (spi_sclk) hi_cnt <= hi_cnt + 1'b1;
        else               hi_cnt <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_cs_n && !spi_sclk && sdio_oe && !busy && !irq));

    p_release_low_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sdio_oe) |-> !spi_sclk);

    p_sclk_high_len_r5: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> (hi_cnt < HW'(STEP_DIV)));

    p_cs_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy != spi_cs_n);

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
endmodule

bind tw_spi_master tw_spi_master_chk #(.STEP_DIV(STEP_DIV)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .irq     (irq),
    .irq_clr (irq_clr),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .sdio_oe (sdio_oe)
);

// File: tb/tw_spi_master_tb_top.sv
module tw_spi_master_tb_top;
    localparam int SD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] wr_bits = '0, rd_bits = '0;
    logic        busy;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0, tx_ready;
    logic [31:0] rx_data;
    logic        rx_valid, rx_ready = 1'b0;
    logic        irq, irq_clr = 1'b0;
    logic        spi_sclk, spi_cs_n, sdio_o, sdio_oe, sdio_i;

    always #5 clk = ~clk;

    tw_spi_master #(.STEP_DIV(SD), .CNT_W(16)) dut_i (
        .clk(clk), .rst(rst), .start(start), .wr_bits(wr_bits), .rd_bits(rd_bits),
        .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .irq(irq), .irq_clr(irq_clr), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] txw [4];
    logic [31:0] dvw [5];
    logic [31:0] rxw [5];
    logic        wcap_bits [256];
    int wcap = 0, redge = 0, hi_len = 0, hi_bad = 0, ta_bad = 0, rd_total = 0, nrx = 0;
    logic prev_sclk = 1'b0, prev_oe = 1'b1, evt_line = 1'b0;

    function automatic logic dev_bit(input int k);
        return dvw[k / 32][31 - (k % 32)];
    endfunction

    assign sdio_i = (!spi_cs_n && !sdio_oe && redge >= 2 && (redge - 2) < rd_total)
                    ? dev_bit(redge - 2) : evt_line;

    always @(negedge clk) begin
        if (spi_sclk && !prev_sclk && !spi_cs_n) begin
            if (sdio_oe) begin
                if (wcap < 256) wcap_bits[wcap] = sdio_o;
                wcap = wcap + 1;
            end else begin
                redge = redge + 1;
            end
        end
        if (spi_sclk) hi_len = hi_len + 1;
        else begin
            if (prev_sclk && hi_len != SD) hi_bad = hi_bad + 1;
            hi_len = 0;
        end
        if (prev_oe && !sdio_oe && spi_sclk) ta_bad = ta_bad + 1;
        prev_sclk = spi_sclk;
        prev_oe   = sdio_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic run_txn(input int nw, input int nr, input int gmax, input bit rnd_rdy,
                           input bit tx_stall, input bit rx_stall, input bit poke);
        for (int i = 0; i < nw; i++) txw[i] = $urandom;
        for (int i = 0; i < nr; i++) dvw[i] = $urandom;
        @(negedge clk);
        wcap = 0; redge = 0; hi_bad = 0; ta_bad = 0; nrx = 0; rd_total = nr * 32;
        wr_bits = 16'(nw * 32 - 1);
        rd_bits = 16'(nr * 32 - 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int i = 0; i < nw; i++) begin
                    int gap;
                    gap = (gmax == 0) ? 0 : int'($urandom % (gmax + 1));
                    if (tx_stall && i == 1) begin
                        repeat (40 * 32 * SD / 8 + 200) @(negedge clk);
                        chk(wcap == 32, "R7 bits sent during stall", 64'(wcap), 64'd32);
                        chk(spi_sclk == 1'b0, "R7 clock low during stall", 64'(spi_sclk), 64'd0);
                    end else begin
                        repeat (gap) @(negedge clk);
                    end
                    tx_valid = 1'b1;
                    tx_data  = txw[i];
                    while (!tx_ready) @(negedge clk);
                    @(negedge clk);
                    tx_valid = 1'b0;
                end
            end
            begin
                if (rx_stall) begin
                    rx_ready = 1'b0;
                    while (!rx_valid) @(negedge clk);
                    repeat (40) @(negedge clk);
                    chk(redge == 34, "R8 edges while held", 64'(redge), 64'd34);
                    chk(spi_sclk == 1'b0, "R8 clock low while held", 64'(spi_sclk), 64'd0);
                    chk(rx_valid && rx_data == dvw[0], "R8 word held", 64'(rx_data), 64'(dvw[0]));
                end
                while (nrx < nr) begin
                    logic r;
                    @(negedge clk);
                    r = rnd_rdy ? logic'($urandom % 2) : 1'b1;
                    if (rx_valid && r) begin
                        rxw[nrx] = rx_data;
                        nrx++;
                    end
                    rx_ready = r;
                end
                @(negedge clk);
                rx_ready = 1'b0;
            end
            begin
                if (poke) begin
                    repeat (20) @(negedge clk);
                    chk(busy && !spi_cs_n, "R6 busy framed", 64'(busy), 64'd1);
                    wr_bits = 16'd5;
                    rd_bits = 16'd7;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R6 cs released", 64'(spi_cs_n), 64'd1);
        chk(wcap == nw * 32, "R2 write bit count", 64'(wcap), 64'(nw * 32));
        begin
            int bad = 0;
            for (int k = 0; k < nw * 32; k++)
                if (wcap_bits[k] !== txw[k / 32][31 - (k % 32)]) bad++;
            chk(bad == 0, "R2 write bits MSB first", 64'(bad), 64'd0);
        end
        chk(redge == 2 + nr * 32, "R3 R4 released rising edges", 64'(redge), 64'(2 + nr * 32));
        chk(ta_bad == 0, "R3 release with clock low", 64'(ta_bad), 64'd0);
        for (int i = 0; i < nr; i++)
            chk(rxw[i] == dvw[i], (i == nr - 1) ? "R4 status word" : "R4 data word",
                64'(rxw[i]), 64'(dvw[i]));
        chk(hi_bad == 0, "R5 clock high length", 64'(hi_bad), 64'd0);
        chk(irq == 1'b0, "R9 no irq before event", 64'(irq), 64'd0);
        evt_line = 1'b1;
        repeat (4 * SD + 2) @(negedge clk);
        chk(irq == 1'b1, "R9 irq on event", 64'(irq), 64'd1);
        evt_line = 1'b0;
        repeat (6) @(negedge clk);
        chk(irq == 1'b1, "R9 irq sticky", 64'(irq), 64'd1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq cleared", 64'(irq), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && busy == 1'b0, "R1 idle framing", {spi_cs_n, busy}, 2'b10);
        chk(spi_sclk == 1'b0, "R1 clock low", 64'(spi_sclk), 64'd0);
        chk(sdio_oe == 1'b1 && sdio_o == 1'b0, "R1 line driven low", {sdio_oe, sdio_o}, 2'b10);
        chk(irq == 1'b0 && rx_valid == 1'b0, "R1 no irq", {irq, rx_valid}, 2'b00);
        run_txn(1, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_txn(1, 3, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_txn(2, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_txn(1, 2, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int t = 0; t < 8; t++)
            run_txn(1 + int'($urandom % 3), 1 + int'($urandom % 4), 5, 1'b1, 1'b0, 1'b0, 1'b0);
        done = 1;
        summary();
        $finish;
    end
endmodule